// File: doc/BRIEF.md
# System-Management Interrupt Status Register Pair

This block collects the interrupt lines that peripheral blocks raise toward system-management firmware and presents them as two 8-bit status bytes on a simple register read port. A read is an index plus a one-cycle strobe. The read data is combinational: it is valid in the same cycle as the strobe and is zero whenever the strobe is low.

Most status bits are level mirrors. Each one is registered once per clock and falls only when its own source drops the line. The parallel-port bit has a second meaning when the port is switched off: in that case it reads 1. The infrared bit is a sticky latch. Either edge on the chosen infrared receive pin sets it, and a read of the second status byte clears it. The infrared pin passes through a synchronizer before edge detection. An edge that lands in the same cycle as a clearing read is not lost.

Both status bytes come up at zero after reset. The level bits take their first sample on the first clock edge after reset is released.

Top module: `smi_status_regs`

## Requirements
- R1: While reset is asserted, and before the first clock edge after it is released, both status bytes read 0x00.
- R2: Status byte 1 (index STAT1_IDX, default 0x16) holds the parallel-port bit at position 1, serial port 2 at position 2, serial port 1 at position 3, the floppy controller at position 4 and the watchdog at position 7. Positions 0, 5 and 6 read 0. Each bit shows its input as sampled on the most recent clock edge.
- R3: Reading either status byte leaves every level bit unchanged. A level bit falls only when its source input falls.
- R4: When pport_active is 0, the parallel-port bit reads 1. When pport_active is 1, it reads the value of pport_ack, with the same one-edge sampling as R2.
- R5: Status byte 2 (index STAT2_IDX, default 0x17) holds mouse at position 0, keyboard at position 1, infrared at position 2 and the keyboard-controller auxiliary bit at position 4. Positions 3, 5, 6 and 7 read 0. The mouse, keyboard and auxiliary bits are level mirrors as in R2.
- R6: Any change of level on the selected infrared pin sets the infrared bit, whether the line rises or falls. The clock edge that first samples the new level is edge j. The bit becomes 1 on edge j+2 and stays set.
- R7: A strobed read of status byte 2 clears the infrared bit on the clock edge that ends the read. The read itself returns the value held before that edge. A read of status byte 1, a read of any other index, or no strobe leaves the infrared bit unchanged.
- R8: If an infrared edge would set the bit on the same clock edge that a status-byte-2 read would clear it, the bit ends up set.
- R9: ir_rx_sel = 0 selects ir_rx_a and ir_rx_sel = 1 selects ir_rx_b. Edges on the pin that is not selected have no effect.
- R10: rd_data is 0x00 when rd_stb is low and when rd_idx matches neither status index.
- R11: The level the infrared pin holds through reset is never taken as an edge. Only changes after reset release can set the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pport_active | input | 1 | Parallel port switched on |
| pport_ack | input | 1 | Parallel-port acknowledge level |
| ser2_irq | input | 1 | Serial port 2 interrupt |
| ser1_irq | input | 1 | Serial port 1 interrupt |
| fdc_irq | input | 1 | Floppy controller interrupt |
| wdt_irq | input | 1 | Watchdog interrupt |
| mouse_irq | input | 1 | Mouse interrupt |
| kbd_irq | input | 1 | Keyboard interrupt |
| kbc_aux | input | 1 | Keyboard-controller auxiliary port bit |
| ir_rx_a | input | 1 | Infrared receive pin A |
| ir_rx_b | input | 1 | Infrared receive pin B |
| ir_rx_sel | input | 1 | Infrared pin select (0 = A, 1 = B) |
| rd_stb | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Register index |
| rd_data | output | 8 | Read data, zero when no register is read |

## Verification
The hardest case to reach is an infrared edge and a clearing read that arrive on the same clock edge. The edge reaches the latch two edges after the pin is sampled, so the read strobe has to be raised a fixed number of cycles after the pin toggles. The stimulus does this by toggling the pin, letting exactly one clock edge pass, and then asserting a status-byte-2 read. Its strobe then covers the edge on which the detected edge lands. A second hard case is reset with the infrared pin held high. That case needs a fresh reset with the pin already high, followed by idle cycles, to show that no edge is created.

// File: rtl/smi_stat_pkg.sv
package smi_stat_pkg;

    // bit positions decoded by firmware
    localparam int S1_PPORT = 1;
    localparam int S1_SER2  = 2;
    localparam int S1_SER1  = 3;
    localparam int S1_FDC   = 4;
    localparam int S1_WDT   = 7;
    localparam int S2_MOUSE = 0;
    localparam int S2_KBD   = 1;
    localparam int S2_IR    = 2;
    localparam int S2_KBC   = 4;

    typedef struct packed {
        logic wdt;
        logic fdc;
        logic ser1;
        logic ser2;
        logic pport;
    } grp1_t;

    typedef struct packed {
        logic kbc;
        logic kbd;
        logic mouse;
    } grp2_t;

    typedef struct packed {
        grp1_t g1;
        grp2_t g2;
    } lvl_t;

    function automatic logic [7:0] pack_stat1(grp1_t g);
        logic [7:0] b;
        b = 8'h00;
        b[S1_PPORT] = g.pport;
        b[S1_SER2]  = g.ser2;
        b[S1_SER1]  = g.ser1;
        b[S1_FDC]   = g.fdc;
        b[S1_WDT]   = g.wdt;
        return b;
    endfunction

    function automatic logic [7:0] pack_stat2(grp2_t g, logic ir);
        logic [7:0] b;
        b = 8'h00;
        b[S2_MOUSE] = g.mouse;
        b[S2_KBD]   = g.kbd;
        b[S2_IR]    = ir;
        b[S2_KBC]   = g.kbc;
        return b;
    endfunction

endpackage

// File: rtl/smi_ir_edge.sv
module smi_ir_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_a,
    input  logic rx_b,
    input  logic sel,
    output logic edge_o
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 2);
    localparam logic [CNT_W-1:0] FILL_DONE = CNT_W'(SYNC_STAGES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CNT_W-1:0]       fill;
    } st_t;

    st_t st_d, st_q;
    logic rx_mux;

    always_comb begin
        rx_mux       = sel ? rx_b : rx_a;
        st_d         = st_q;
        st_d.sync    = {st_q.sync[SYNC_STAGES-2:0], rx_mux};
        st_d.prev    = st_q.sync[SYNC_STAGES-1];
        if (st_q.fill != FILL_DONE) begin
            st_d.fill = st_q.fill + 1'b1;
        end
        edge_o = (st_q.fill == FILL_DONE) &&
                 (st_q.sync[SYNC_STAGES-1] != st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/smi_ir_latch.sv
module smi_ir_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;      // set wins over a simultaneous clear
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/smi_read_mux.sv
module smi_read_mux #(
    parameter int                IDX_W     = 8,
    parameter logic [IDX_W-1:0]  STAT1_IDX = 8'h16,
    parameter logic [IDX_W-1:0]  STAT2_IDX = 8'h17
) (
    input  logic [7:0]       stat1,
    input  logic [7:0]       stat2,
    input  logic             rd_stb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             hit2
);
    always_comb begin
        rd_data = 8'h00;
        hit2    = 1'b0;
        if (rd_stb) begin
            if (rd_idx == STAT1_IDX) begin
                rd_data = stat1;
            end else if (rd_idx == STAT2_IDX) begin
                rd_data = stat2;
                hit2    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/smi_status_regs.sv
module smi_status_regs
    import smi_stat_pkg::*;
#(
    parameter int                IDX_W       = 8,
    parameter logic [IDX_W-1:0]  STAT1_IDX   = 8'h16,
    parameter logic [IDX_W-1:0]  STAT2_IDX   = 8'h17,
    parameter int                SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pport_active,
    input  logic             pport_ack,
    input  logic             ser2_irq,
    input  logic             ser1_irq,
    input  logic             fdc_irq,
    input  logic             wdt_irq,
    input  logic             mouse_irq,
    input  logic             kbd_irq,
    input  logic             kbc_aux,
    input  logic             ir_rx_a,
    input  logic             ir_rx_b,
    input  logic             ir_rx_sel,
    input  logic             rd_stb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    lvl_t lvl_d, lvl_q;
    logic ir_edge;
    logic ir_flag;
    logic hit2;
    logic [7:0] stat1, stat2;

    // level mirrors, sampled once per clock
    always_comb begin
        lvl_d.g1.pport = pport_active ? pport_ack : 1'b1;
        lvl_d.g1.ser2  = ser2_irq;
        lvl_d.g1.ser1  = ser1_irq;
        lvl_d.g1.fdc   = fdc_irq;
        lvl_d.g1.wdt   = wdt_irq;
        lvl_d.g2.mouse = mouse_irq;
        lvl_d.g2.kbd   = kbd_irq;
        lvl_d.g2.kbc   = kbc_aux;
        stat1 = pack_stat1(lvl_q.g1);
        stat2 = pack_stat2(lvl_q.g2, ir_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    smi_ir_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_a   (ir_rx_a),
        .rx_b   (ir_rx_b),
        .sel    (ir_rx_sel),
        .edge_o (ir_edge)
    );

    smi_ir_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ir_edge),
        .clr_i  (hit2),
        .flag_o (ir_flag)
    );

    smi_read_mux #(
        .IDX_W     (IDX_W),
        .STAT1_IDX (STAT1_IDX),
        .STAT2_IDX (STAT2_IDX)
    ) u_mux (
        .stat1   (stat1),
        .stat2   (stat2),
        .rd_stb  (rd_stb),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .hit2    (hit2)
    );
endmodule

// File: rtl/smi_status_chk.sv
module smi_status_chk #(
    parameter int                IDX_W     = 8,
    parameter logic [IDX_W-1:0]  STAT1_IDX = 8'h16,
    parameter logic [IDX_W-1:0]  STAT2_IDX = 8'h17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pport_active,
    input logic             ser1_irq,
    input logic             rd_stb,
    input logic [IDX_W-1:0] rd_idx,
    input logic [7:0]       rd_data,
    input logic             ir_edge,
    input logic             ir_flag
);
    logic rd1, rd2;
    assign rd1 = rd_stb && (rd_idx == STAT1_IDX);
    assign rd2 = rd_stb && (rd_idx == STAT2_IDX);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd1 && !rd2) |-> (rd_data == 8'h00));

    a_r2_reserved1: assert property (@(posedge clk) disable iff (!rst_n)
        rd1 |-> (rd_data[0] == 1'b0 && rd_data[6:5] == 2'b00));

    a_r5_reserved2: assert property (@(posedge clk) disable iff (!rst_n)
        rd2 |-> (rd_data[3] == 1'b0 && rd_data[7:5] == 3'b000));

    a_r2_ser1_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1 && $past(rst_n)) |-> (rd_data[3] == $past(ser1_irq)));

    a_r4_pport_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1 && $past(rst_n) && !$past(pport_active)) |-> rd_data[1]);

    a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ir_edge |=> ir_flag);

    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_flag && !rd2) |=> ir_flag);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd2 && !ir_edge) |=> !ir_flag);
endmodule

bind smi_status_regs smi_status_chk #(
    .IDX_W     (IDX_W),
    .STAT1_IDX (STAT1_IDX),
    .STAT2_IDX (STAT2_IDX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pport_active (pport_active),
    .ser1_irq     (ser1_irq),
    .rd_stb       (rd_stb),
    .rd_idx       (rd_idx),
    .rd_data      (rd_data),
    .ir_edge      (ir_edge),
    .ir_flag      (ir_flag)
);

// File: tb/tb_smi_status_regs.sv
`timescale 1ns/1ps
module tb_smi_status_regs;
    localparam logic [7:0] I1 = 8'h16;
    localparam logic [7:0] I2 = 8'h17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pport_active = 0, pport_ack = 0, ser2_irq = 0, ser1_irq = 0;
    logic fdc_irq = 0, wdt_irq = 0, mouse_irq = 0, kbd_irq = 0, kbc_aux = 0;
    logic ir_rx_a = 0, ir_rx_b = 0, ir_rx_sel = 0, rd_stb = 0;
    logic [7:0] rd_idx = 8'h00;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    smi_status_regs dut (
        .clk(clk), .rst_n(rst_n), .pport_active(pport_active), .pport_ack(pport_ack),
        .ser2_irq(ser2_irq), .ser1_irq(ser1_irq), .fdc_irq(fdc_irq), .wdt_irq(wdt_irq),
        .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .kbc_aux(kbc_aux),
        .ir_rx_a(ir_rx_a), .ir_rx_b(ir_rx_b), .ir_rx_sel(ir_rx_sel),
        .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_s1 = 0, m_s2lvl = 0;
    bit m_ir = 0;
    bit hist[$];
    int cyc = 0;

    function automatic logic [7:0] model_read();
        if (!rst_n || !rd_stb) return 8'h00;
        if (rd_idx == I1) return m_s1;
        if (rd_idx == I2) return m_s2lvl | {5'b0, m_ir, 2'b0};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2lvl = 0; m_ir = 0; cyc = 0; hist.delete();
        end else begin
            bit ev, rd2;
            cyc++;
            hist.push_back(ir_rx_sel ? ir_rx_b : ir_rx_a);
            if (hist.size() > 4) void'(hist.pop_front());
            ev  = (cyc >= 4) && (hist[1] != hist[0]);
            rd2 = rd_stb && (rd_idx == I2);
            if (ev) m_ir = 1;
            else if (rd2) m_ir = 0;
            m_s1 = {wdt_irq, 2'b00, fdc_irq, ser1_irq, ser2_irq,
                    (pport_active ? pport_ack : 1'b1), 1'b0};
            m_s2lvl = {3'b000, kbc_aux, 2'b00, kbd_irq, mouse_irq};
        end
        #3;
        begin
            logic [7:0] e;
            string tag;
            e = model_read();
            tag = (rd_stb && rd_idx == I1) ? "R2" : (rd_stb && rd_idx == I2) ? "R5" : "R10";
            tests++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s per-cycle model: actual %02h expected %02h", tag, rd_data, e);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [7:0] idx, logic [7:0] exp, string tag);
        @(negedge clk);
        rd_stb = 1; rd_idx = idx;
        #1 chk(tag, rd_data, exp);
        @(negedge clk);
        rd_stb = 0;
    endtask

    initial begin
        idle(3);
        rd_stb = 1; rd_idx = I1; #1 chk("R1 reset stat1", rd_data, 8'h00);
        rd_idx = I2; #1 chk("R1 reset stat2", rd_data, 8'h00);
        rd_stb = 0;
        @(negedge clk); rst_n = 1;
        rd_stb = 1; rd_idx = I1; #1 chk("R1 before first edge", rd_data, 8'h00);
        rd_stb = 0;
        idle(1);
        rd(I1, 8'h02, "R4 port off reads 1");
        ser1_irq = 1; ser2_irq = 1; fdc_irq = 1; wdt_irq = 1;
        pport_active = 1; pport_ack = 0;
        rd(I1, 8'h9C, "R2 layout");
        rd(I1, 8'h9C, "R3 read does not clear");
        pport_ack = 1;
        rd(I1, 8'h9E, "R4 follows ack");
        ser1_irq = 0; fdc_irq = 0;
        rd(I1, 8'h86, "R3 source clear");
        ser2_irq = 0; wdt_irq = 0; pport_ack = 0;
        mouse_irq = 1; kbd_irq = 1; kbc_aux = 1;
        rd(I2, 8'h13, "R5 layout");
        rd(I2, 8'h13, "R3 stat2 read keeps levels");
        mouse_irq = 0; kbd_irq = 0; kbc_aux = 0;
        rd(I2, 8'h00, "R5 sources cleared");
        // R6 rising edge
        ir_rx_a = 1; idle(4);
        rd(I1, 8'h00, "R7 stat1 read");
        rd(I2, 8'h04, "R6 rise sets");
        rd(I2, 8'h00, "R7 read clears");
        // R6 falling edge
        ir_rx_a = 0; idle(4);
        rd(8'h40, 8'h00, "R10 other index");
        rd(I2, 8'h04, "R6 fall sets");
        rd(I2, 8'h00, "R7 cleared again");
        // R8 collision
        @(negedge clk); ir_rx_a = 1;
        @(negedge clk);
        rd(I2, 8'h00, "R8 read at set edge");
        rd(I2, 8'h04, "R8 set survives read");
        rd(I2, 8'h00, "R8 then cleared");
        // R9 unselected pin
        ir_rx_b = 1; idle(2); ir_rx_b = 0; idle(4);
        rd(I2, 8'h00, "R9 unselected ignored");
        ir_rx_b = ir_rx_a; idle(1); ir_rx_sel = 1; idle(4);
        rd(I2, 8'h00, "R9 switch equal levels");
        ir_rx_b = ~ir_rx_b; idle(4);
        rd(I2, 8'h04, "R9 pin B selected");
        ir_rx_a = ~ir_rx_a; idle(4);
        rd(I2, 8'h00, "R9 pin A now ignored");
        // R10 no strobe
        wdt_irq = 1; idle(2);
        @(negedge clk); rd_idx = I1; rd_stb = 0;
        #1 chk("R10 no strobe", rd_data, 8'h00);
        wdt_irq = 0;
        // R11 high through reset
        @(negedge clk); rst_n = 0; ir_rx_sel = 0; ir_rx_a = 1; ir_rx_b = 1;
        idle(3); rst_n = 1; idle(8);
        rd(I2, 8'h00, "R11 reset level not an edge");
        ir_rx_a = 0; idle(4);
        rd(I2, 8'h04, "R11 later edge still sets");
        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule